// File: doc/BRIEF.md
# Horizontal Accumulating Integer Prescaler

This block lowers the horizontal resolution of a pixel stream by a whole-number factor. Each valid input sample enters a sliding window whose length is programmable. A decimation counter picks every N-th sample of the line, and on that sample the block emits the window sum. The sum first passes through a power-of-two renormalization with round-half-up and is then clamped to the output range. The window length and the decimation ratio are set independently, so windows may overlap (length greater than ratio) or leave gaps (length less than ratio).

Two sets of configuration inputs each hold a ratio, a window length and a gain code. A bank select input chooses between them. All configuration is captured only in the line-start cycle and stays fixed for the rest of the line. A line-start pulse clears the counter and the window history, so samples from an earlier line never enter a sum. A ratio of zero is illegal. It is run as a ratio of one and raises a flag that holds until reset.

Top module: `hacc_prescaler`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` and `cfg_err` are 0.
- R2: With a captured ratio N (1..63), exactly one output is produced for every N valid samples, counted from line start. `out_valid` is high for one cycle, in the cycle after the N-th, 2N-th, ... sample is accepted.
- R3: For a captured length field K, the output is built from the sum of the K+1 most recent accepted samples of the current line, up to and including the sample that completes the ratio count. Window positions that fall before the line start count as zero.
- R4: For gain code g from 0 to 6, the output is (sum + 2^(g-1)) >> g, with no rounding term when g is 0. Code 7 acts as code 6.
- R5: A renormalized value above 255 is output as 255.
- R6: A ratio field of 0 captured at line start makes the line run as ratio 1 and sets `cfg_err`. `cfg_err` stays set until reset.
- R7: A `line_start` cycle clears the ratio count and the window history. A sample presented with `pix_valid` in that cycle is discarded, and `out_valid` is 0 in the cycle after it.
- R8: `bank_sel` (0 selects the `_a` inputs, 1 selects the `_b` inputs) and all field inputs are sampled only in the `line_start` cycle. Changing them later in the line has no effect on the outputs.
- R9: A cycle with `pix_valid` low advances neither the count nor the window, and `out_valid` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | One-cycle pulse that opens a new line |
| pix_valid | input | 1 | Input sample strobe |
| pix_data | input | 8 | Input sample |
| bank_sel | input | 1 | Configuration set select (0 = a, 1 = b) |
| ratio_a | input | 6 | Set a decimation ratio |
| len_a | input | 6 | Set a window length minus one |
| gain_a | input | 3 | Set a renormalization shift code |
| ratio_b | input | 6 | Set b decimation ratio |
| len_b | input | 6 | Set b window length minus one |
| gain_b | input | 3 | Set b renormalization shift code |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 8 | Output sample |
| cfg_err | output | 1 | Sticky flag: a zero ratio was captured |

## Verification
A wrong decimation count appears on the very first expected output of a line, as a strobe one or more samples early or late. A corrupt window history or running sum appears as wrong data on the first emitted output whose window reaches the damaged entry, which can take up to 64 samples. Leftover state from a previous line shows on the first output of the next line. A missed capture of configuration shows only on lines whose two banks, or whose fields before and after the mid-line change, differ. For this reason the tests drive distinct values into the unused bank and scramble the fields mid-line.

// File: rtl/hacc_pkg.sv
// Package: shared field widths and the captured configuration record.
// Assumes all users take field widths from here so banks stay consistent.
package hacc_pkg;
    localparam int RATIO_W   = 6;
    localparam int LEN_W     = 6;
    localparam int GAIN_W    = 3;
    localparam int MAX_SHIFT = 6;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [LEN_W-1:0]   len;
        logic [GAIN_W-1:0]  gain;
    } hacc_cfg_t;
endpackage

// File: rtl/hacc_cfg_latch.sv
// Configuration capture: picks one of two banks and freezes it at line start.
// Assumes line_start is a single-cycle pulse; a zero ratio is replaced by one
// and recorded in a flag that only reset clears.
module hacc_cfg_latch
    import hacc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      line_start,
    input  logic      bank_sel,
    input  hacc_cfg_t bank0,
    input  hacc_cfg_t bank1,
    output hacc_cfg_t act,
    output logic      zero_err
);
    hacc_cfg_t sel;
    hacc_cfg_t act_q;
    logic      err_q;

    // Bank multiplexer.
    always_comb sel = bank_sel ? bank1 : bank0;

    // Capture of the selected bank and the illegal-ratio flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '{ratio: RATIO_W'(1), len: '0, gain: '0};
            err_q <= 1'b0;
        end else if (line_start) begin
            act_q.ratio <= (sel.ratio == '0) ? RATIO_W'(1) : sel.ratio;
            act_q.len   <= sel.len;
            act_q.gain  <= sel.gain;
            if (sel.ratio == '0)
                err_q <= 1'b1;
        end
    end

    assign act      = act_q;
    assign zero_err = err_q;

    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(act_q));
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    p_ratio_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (act_q.ratio != '0));
endmodule

// File: rtl/hacc_decim.sv
// Decimation counter: flags every RATIO-th accepted sample of a line.
// Assumes ratio is nonzero and constant between clears.
module hacc_decim #(
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               step,
    input  logic [RATIO_W-1:0] ratio,
    output logic               wrap
);
    logic [RATIO_W-1:0] cnt_q;

    // Wrap marks the sample that completes the current period.
    always_comb wrap = step && (cnt_q == ratio - RATIO_W'(1));

    // Period counter, cleared at line start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (step)
            cnt_q <= wrap ? '0 : cnt_q + RATIO_W'(1);
    end

    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio);
endmodule

// File: rtl/hacc_window.sv
// Sliding-window summer: keeps the last 2**LEN_W samples and a running sum of
// the newest len+1 of them. Assumes len is constant between clears, so the
// running sum always equals the sum of history taps 0..len.
module hacc_window #(
    parameter int PIX_W = 8,
    parameter int LEN_W = 6,
    parameter int SUM_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [LEN_W-1:0] len,
    input  logic [PIX_W-1:0] pix,
    output logic [SUM_W-1:0] sum_next
);
    localparam int DEPTH = 1 << LEN_W;

    logic [DEPTH-1:0][PIX_W-1:0] hist_q;
    logic [SUM_W-1:0]            sum_q;
    logic [PIX_W-1:0]            drop;

    // Sample leaving the window when a new one enters.
    always_comb begin
        drop     = hist_q[len];
        sum_next = sum_q + SUM_W'(pix) - SUM_W'(drop);
    end

    // History delay line; newest sample at tap 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            hist_q <= '0;
        else if (step)
            hist_q <= {hist_q[DEPTH-2:0], pix};
    end

    // Running window sum.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            sum_q <= '0;
        else if (step)
            sum_q <= sum_next;
    end

    p_line_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum_q == '0));
    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(sum_q));
endmodule

// File: rtl/hacc_renorm.sv
// Renormalizer and output register: shifts the window sum right by the gain
// code with round-half-up, clamps to the pixel range, and registers the result
// on decimation points. Assumes codes above MAX_SHIFT act as MAX_SHIFT.
module hacc_renorm #(
    parameter int PIX_W     = 8,
    parameter int SUM_W     = 14,
    parameter int GAIN_W    = 3,
    parameter int MAX_SHIFT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wrap,
    input  logic [SUM_W-1:0]  sum,
    input  logic [GAIN_W-1:0] gain,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_data
);
    localparam int EXT_W = SUM_W + 1;
    localparam logic [EXT_W-1:0] PIX_MAX = EXT_W'((1 << PIX_W) - 1);

    logic [GAIN_W-1:0] g;
    logic [EXT_W-1:0]  rnd;
    logic [EXT_W-1:0]  shifted;
    logic [PIX_W-1:0]  clamped;

    // Shift, round and clamp.
    always_comb begin
        g       = (gain > GAIN_W'(MAX_SHIFT)) ? GAIN_W'(MAX_SHIFT) : gain;
        rnd     = (g == '0) ? '0 : (EXT_W'(1) << (g - GAIN_W'(1)));
        shifted = (EXT_W'(sum) + rnd) >> g;
        clamped = (shifted > PIX_MAX) ? PIX_MAX[PIX_W-1:0] : shifted[PIX_W-1:0];
    end

    // Output strobe and data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= en && wrap;
            if (en && wrap)
                out_data <= clamped;
        end
    end

    p_out_needs_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(en));
    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && wrap) |=> $stable(out_data));
endmodule

// File: rtl/hacc_prescaler.sv
// Top: horizontal accumulating integer prescaler. Joins configuration capture,
// decimation counter, sliding-window summer and renormalizer. Assumes the
// line_start pulse comes with no sample of its own (any sample in that cycle
// is dropped).
module hacc_prescaler
    import hacc_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic               pix_valid,
    input  logic [PIX_W-1:0]   pix_data,
    input  logic               bank_sel,
    input  logic [RATIO_W-1:0] ratio_a,
    input  logic [LEN_W-1:0]   len_a,
    input  logic [GAIN_W-1:0]  gain_a,
    input  logic [RATIO_W-1:0] ratio_b,
    input  logic [LEN_W-1:0]   len_b,
    input  logic [GAIN_W-1:0]  gain_b,
    output logic               out_valid,
    output logic [PIX_W-1:0]   out_data,
    output logic               cfg_err
);
    localparam int LEN_MAX = 1 << LEN_W;
    localparam int SUM_W   = $clog2(LEN_MAX * ((1 << PIX_W) - 1) + 1);

    hacc_cfg_t        bank0, bank1, act;
    logic             step, wrap;
    logic [SUM_W-1:0] sum_next;

    // Pack bank fields and qualify the sample strobe.
    always_comb begin
        bank0 = '{ratio: ratio_a, len: len_a, gain: gain_a};
        bank1 = '{ratio: ratio_b, len: len_b, gain: gain_b};
        step  = pix_valid && !line_start;
    end

    hacc_cfg_latch u_cfg (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .bank_sel(bank_sel),
        .bank0(bank0), .bank1(bank1), .act(act), .zero_err(cfg_err)
    );

    hacc_decim #(.RATIO_W(RATIO_W)) u_decim (
        .clk(clk), .rst_n(rst_n), .clr(line_start), .step(step),
        .ratio(act.ratio), .wrap(wrap)
    );

    hacc_window #(.PIX_W(PIX_W), .LEN_W(LEN_W), .SUM_W(SUM_W)) u_win (
        .clk(clk), .rst_n(rst_n), .clr(line_start), .step(step),
        .len(act.len), .pix(pix_data), .sum_next(sum_next)
    );

    hacc_renorm #(.PIX_W(PIX_W), .SUM_W(SUM_W), .GAIN_W(GAIN_W),
                  .MAX_SHIFT(MAX_SHIFT)) u_norm (
        .clk(clk), .rst_n(rst_n), .en(step), .wrap(wrap), .sum(sum_next),
        .gain(act.gain), .out_valid(out_valid), .out_data(out_data)
    );

    p_ls_no_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !out_valid);
endmodule

// File: tb/sim_hacc_prescaler.sv
module sim_hacc_prescaler;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, line_start, pix_valid, bank_sel;
    logic [7:0] pix_data;
    logic [5:0] ratio_a, len_a, ratio_b, len_b;
    logic [2:0] gain_a, gain_b;
    logic       out_valid, cfg_err;
    logic [7:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit err_model = 1'b0;
    int lp [0:255];

    hacc_prescaler u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_valid(pix_valid),
        .pix_data(pix_data), .bank_sel(bank_sel),
        .ratio_a(ratio_a), .len_a(len_a), .gain_a(gain_a),
        .ratio_b(ratio_b), .len_b(len_b), .gain_b(gain_b),
        .out_valid(out_valid), .out_data(out_data), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [5:0] ratio;
        logic [5:0] len;
        logic [2:0] gain;
        logic       bank;
        logic [7:0] step;
        logic [7:0] base;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{6'd1,  6'd0,  3'd0, 1'b0, 8'd7,  8'd3},
        '{6'd2,  6'd1,  3'd1, 1'b1, 8'd11, 8'd0},
        '{6'd4,  6'd3,  3'd2, 1'b0, 8'd13, 8'd5},
        '{6'd3,  6'd5,  3'd1, 1'b1, 8'd29, 8'd40},
        '{6'd63, 6'd63, 3'd6, 1'b0, 8'd5,  8'd0},
        '{6'd1,  6'd63, 3'd6, 1'b1, 8'd3,  8'd9},
        '{6'd5,  6'd1,  3'd0, 1'b0, 8'd17, 8'd100},
        '{6'd7,  6'd2,  3'd7, 1'b1, 8'd9,  8'd250}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic int exp_val(input int sum, input int g);
        int gg, r;
        gg = (g > 6) ? 6 : g;
        r  = (gg == 0) ? sum : ((sum + (1 << (gg - 1))) >> gg);
        return (r > 255) ? 255 : r;
    endfunction

    // Runs one line: line-start cycle, then npix samples, then an idle cycle.
    task automatic run_line(input int ratio, input int len, input int gain,
                            input bit bank, input int stp, input int base,
                            input int npix, input bit gap, input bit scramble,
                            input bit junk, input string dreq);
        int neff;
        @(negedge clk);
        if (bank) begin
            ratio_b = 6'(ratio); len_b = 6'(len); gain_b = 3'(gain);
            ratio_a = 6'd3; len_a = 6'd2; gain_a = 3'd5;
        end else begin
            ratio_a = 6'(ratio); len_a = 6'(len); gain_a = 3'(gain);
            ratio_b = 6'd3; len_b = 6'd2; gain_b = 3'd5;
        end
        bank_sel   = bank;
        line_start = 1'b1;
        pix_valid  = junk;
        pix_data   = 8'hFF;
        if (ratio == 0) err_model = 1'b1;
        neff = (ratio == 0) ? 1 : ratio;
        cyc();
        chk(!out_valid, "R7", int'(out_valid), 0);
        for (int i = 0; i < npix; i++) begin
            @(negedge clk);
            line_start = 1'b0;
            if (scramble) begin
                ratio_a = 6'd1; len_a = 6'd0; gain_a = 3'd0;
                ratio_b = 6'd1; len_b = 6'd0; gain_b = 3'd0;
                bank_sel = ~bank;
            end
            if (gap && (i % 3 == 1)) begin
                pix_valid = 1'b0;
                pix_data  = 8'(i * 37);
                cyc();
                chk(!out_valid, "R9", int'(out_valid), 0);
                @(negedge clk);
            end
            lp[i]     = (base + i * stp) & 255;
            pix_valid = 1'b1;
            pix_data  = 8'(lp[i]);
            cyc();
            if (((i + 1) % neff) == 0) begin
                int s = 0;
                for (int j = i; j >= 0 && j > i - (len + 1); j--) s += lp[j];
                chk(out_valid, "R2", int'(out_valid), 1);
                chk(out_valid && int'(out_data) == exp_val(s, gain), dreq,
                    out_valid ? int'(out_data) : -1, exp_val(s, gain));
            end else begin
                chk(!out_valid, "R2", int'(out_valid), 0);
            end
        end
        @(negedge clk);
        pix_valid = 1'b0;
        cyc();
        chk(!out_valid, "R9", int'(out_valid), 0);
        chk(cfg_err == err_model, "R6", int'(cfg_err), int'(err_model));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        line_start = 1'b0; pix_valid = 1'b0; pix_data = '0; bank_sel = 1'b0;
        ratio_a = 6'd1; len_a = '0; gain_a = '0;
        ratio_b = 6'd1; len_b = '0; gain_b = '0;
        repeat (3) cyc();
        @(negedge clk);
        rst_n = 1'b1;
        err_model = 1'b0;
        cyc();
        chk(!out_valid, "R1", int'(out_valid), 0);
        chk(!cfg_err, "R1", int'(cfg_err), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL R2 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        // Table-driven lines: ratio, window, gain and bank combinations.
        for (int v = 0; v < NVEC; v++)
            run_line(VECS[v].ratio, VECS[v].len, VECS[v].gain, VECS[v].bank,
                     VECS[v].step, VECS[v].base, 70, 1'b0, 1'b0, 1'b0, "R3");
        // R4: half-way rounding (sums 1,3,5,7 with shift 1) and code 7.
        run_line(1, 1, 1, 1'b0, 1, 1, 8, 1'b0, 1'b0, 1'b0, "R4");
        run_line(2, 9, 7, 1'b1, 23, 11, 20, 1'b0, 1'b0, 1'b0, "R4");
        // R5: saturation with a large window and no shift.
        run_line(2, 7, 0, 1'b0, 0, 200, 10, 1'b0, 1'b0, 1'b0, "R5");
        run_line(8, 63, 0, 1'b1, 1, 255, 16, 1'b0, 1'b0, 1'b0, "R5");
        // R7: partial period, then a new line whose start cycle carries a sample.
        run_line(4, 3, 0, 1'b0, 60, 10, 6, 1'b0, 1'b0, 1'b0, "R7");
        run_line(4, 3, 0, 1'b0, 31, 7, 9, 1'b0, 1'b0, 1'b1, "R7");
        // R8: fields and bank select scrambled after capture.
        run_line(3, 4, 2, 1'b1, 19, 2, 15, 1'b0, 1'b1, 1'b0, "R8");
        run_line(5, 6, 1, 1'b0, 7, 90, 15, 1'b0, 1'b1, 1'b0, "R8");
        // R9: idle gaps inside the line.
        run_line(3, 2, 1, 1'b0, 21, 4, 15, 1'b1, 1'b0, 1'b0, "R9");
        // R6: zero ratio runs as one and the flag sticks across a legal line.
        run_line(0, 0, 0, 1'b1, 41, 3, 6, 1'b0, 1'b0, 1'b0, "R6");
        run_line(2, 1, 1, 1'b0, 5, 5, 6, 1'b0, 1'b0, 1'b0, "R6");
        // R1: reset clears the sticky flag.
        do_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule